// File: doc/BRIEF.md
# Page Map Reference and Dirty Flag Updater

This block translates a virtual page-and-word address into a real address through a small internal page map. While doing so it keeps each map entry's usage flags current. Each map entry is 16 bits wide. The upper byte holds the real page number. The lower byte holds status flags: 0x80 means referenced, 0x40 means dirty, 0x04 means write-protected and 0x08 means vacant. A lookup reads the entry, sorts it into one of four page states (clean, dirty, write-protected, vacant) and writes back an updated entry when a flag has to change. It then either returns the real address or raises a fault.

A requester presents a segment, a virtual address, an access kind (read for a source operand, write for a destination operand) and an optional page-step command. The request uses a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester keeps the request fields stable. Results come back as one-cycle pulses with no back-pressure. A separate fill port loads the map contents before lookups start.

With page stepping requested, the block first moves the virtual address by one page (0x100 words) forward or backward. When that move carries out of or borrows from the virtual address, the block also moves the segment by one. The lookup then uses the moved address.

Top module: `page_map_updater`

## Requirements
- R1: `req_ready` is 1 only in the idle state. It drops in the cycle after a request is accepted and stays 0 until the result pulse.
- R2: A read access to a page that is not vacant completes with `done`. If flag 0x80 is clear, it first writes the entry back with 0x80 set and all other bits unchanged.
- R3: A read access to a vacant page (flag 0x08 set) pulses `fault_src`, gives no `done` and makes no map write.
- R4: A write access to a clean page writes the entry back with 0xC0 set. It then repeats the lookup, finds the page dirty and ends with `done`.
- R5: A write access to a page whose dirty flag 0x40 is already set ends with `done`. It writes 0x80 back only if that flag was missing.
- R6: A write access to a write-protected (0x04) or vacant (0x08) page pulses `fault_dst`, gives no `done` and makes no map write.
- R7: On `done`, `real_addr` equals the entry's upper byte followed by the low 8 bits of the virtual address. Flag bits never appear in it.
- R8: Page state is decided with vacant first, then write-protected, then dirty (0x40), else clean.
- R9: With `req_step`=1 and `req_back`=0, the virtual address grows by 0x100. A carry out of its 12 bits adds 1 to the segment.
- R10: With `req_step`=1 and `req_back`=1, the virtual address shrinks by 0x100. A borrow subtracts 1 from the segment. With `req_step`=0, `req_back` has no effect.
- R11: `done`, `fault_src` and `fault_dst` are one-cycle pulses, never two at once. A map write occurs only when the written entry differs from the entry read.
- R12: After reset, `req_ready`=1 and `done`, `fault_src`, `fault_dst` and `map_wr_stb` are 0.

The map index is the segment (4 bits) followed by virtual address bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_seg | input | 4 | Segment of the virtual address |
| req_va | input | 12 | Virtual page (11:8) and word (7:0) |
| req_write | input | 1 | 1 = destination write access, 0 = source read access |
| req_step | input | 1 | Step the address by one page before lookup |
| req_back | input | 1 | Step direction, 1 = backward |
| fill_we | input | 1 | Load one map entry |
| fill_idx | input | 8 | Map index to load |
| fill_data | input | 16 | Entry value to load |
| map_wr_stb | output | 1 | Flag write-back strobe |
| map_wr_data | output | 16 | Entry value written back |
| real_addr | output | 16 | Real page and word |
| done | output | 1 | Lookup completed pulse |
| fault_src | output | 1 | Read access fault pulse |
| fault_dst | output | 1 | Write access fault pulse |

## Verification
The bench aims at the cases where page state and access kind interact. A read to a write-protected page must succeed, not fault. A write to a clean page must take the retry path, and a design that skipped the retry would finish without setting the dirty flag or would loop. Entries that carry both vacant and protected flags, or both protected and dirty flags, expose a wrong state priority as a wrong fault or a false `done`. A second access to an already referenced page catches a design that rewrites unchanged entries. Stepped requests that carry into or borrow from the segment, checked against decoy vacant entries at the unstepped index, catch a design that drops the segment adjustment or looks up the wrong page.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int FLAG_W = 8;
  localparam logic [FLAG_W-1:0] FL_REF   = 8'h80;
  localparam logic [FLAG_W-1:0] FL_DIRTY = 8'h40;
  localparam logic [FLAG_W-1:0] FL_VAC   = 8'h08;
  localparam logic [FLAG_W-1:0] FL_PROT  = 8'h04;

  typedef enum logic [1:0] {PG_CLEAN, PG_DIRTY, PG_PROT, PG_VACANT} pg_state_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_CLASS} fsm_e;
endpackage

// File: rtl/pmap_step.sv
module pmap_step #(
  parameter int SEG_W  = 4,
  parameter int VA_W   = 12,
  parameter int WORD_W = 8
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             en_i,
  input  logic             back_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [VA_W-1:0]  va_o
);
  localparam logic [VA_W:0] STEP = (VA_W+1)'(1) << WORD_W;

  logic [VA_W:0] ext;
  logic [VA_W:0] res;
  logic          edge_bit;

  always_comb begin
    ext      = {1'b0, va_i};
    res      = back_i ? (ext - STEP) : (ext + STEP);
    edge_bit = res[VA_W];
    if (!en_i) begin
      va_o  = va_i;
      seg_o = seg_i;
    end else begin
      va_o  = res[VA_W-1:0];
      seg_o = back_i ? (seg_i - SEG_W'(edge_bit)) : (seg_i + SEG_W'(edge_bit));
    end
  end
endmodule

// File: rtl/pmap_classify.sv
module pmap_classify import pmap_pkg::*; #(
  parameter int ENTRY_W = 16
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               is_wr_i,
  output logic [ENTRY_W-1:0] wdata_o,
  output logic               need_wr_o,
  output logic               fault_o,
  output logic               retry_o
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] mask;
  pg_state_e         st;

  always_comb begin
    flags = entry_i[FLAG_W-1:0];
    if ((flags & FL_VAC) != '0)        st = PG_VACANT;
    else if ((flags & FL_PROT) != '0)  st = PG_PROT;
    else if ((flags & FL_DIRTY) != '0) st = PG_DIRTY;
    else                               st = PG_CLEAN;

    if (is_wr_i) begin
      mask    = FL_REF | FL_DIRTY;
      fault_o = (st == PG_PROT) || (st == PG_VACANT);
      retry_o = (st == PG_CLEAN);
    end else begin
      mask    = FL_REF;
      fault_o = (st == PG_VACANT);
      retry_o = 1'b0;
    end
    wdata_o   = entry_i | ENTRY_W'(mask);
    need_wr_o = !fault_o && (wdata_o != entry_i);
  end
endmodule

// File: rtl/pmap_ram.sv
module pmap_ram #(
  parameter int IDX_W   = 8,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               fill_we,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ENTRY_W-1:0] fill_data,
  input  logic               upd_we,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [ENTRY_W-1:0] upd_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (upd_we)       mem[upd_idx]  <= upd_data;
    else if (fill_we) mem[fill_idx] <= fill_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/page_map_updater.sv
module page_map_updater import pmap_pkg::*; #(
  parameter int SEG_W   = 4,
  parameter int VA_W    = 12,
  parameter int WORD_W  = 8,
  parameter int RPAGE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [SEG_W-1:0]                  req_seg,
  input  logic [VA_W-1:0]                   req_va,
  input  logic                              req_write,
  input  logic                              req_step,
  input  logic                              req_back,
  input  logic                              fill_we,
  input  logic [SEG_W+VA_W-WORD_W-1:0]      fill_idx,
  input  logic [RPAGE_W+FLAG_W-1:0]         fill_data,
  output logic                              map_wr_stb,
  output logic [RPAGE_W+FLAG_W-1:0]         map_wr_data,
  output logic [RPAGE_W+WORD_W-1:0]         real_addr,
  output logic                              done,
  output logic                              fault_src,
  output logic                              fault_dst
);
  localparam int PG_W    = VA_W - WORD_W;
  localparam int IDX_W   = SEG_W + PG_W;
  localparam int ENTRY_W = RPAGE_W + FLAG_W;
  localparam logic [VA_W-1:0] PAGE_STEP = VA_W'(1) << WORD_W;

  fsm_e               st;
  logic [SEG_W-1:0]   seg_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [SEG_W-1:0]   seg_n;
  logic [VA_W-1:0]    va_n;
  logic [IDX_W-1:0]   idx;
  logic [ENTRY_W-1:0] ram_q;
  logic [ENTRY_W-1:0] cls_wdata;
  logic               cls_need_wr;
  logic               cls_fault;
  logic               cls_retry;
  logic               accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign idx       = {seg_q, va_q[VA_W-1:WORD_W]};

  pmap_step #(.SEG_W(SEG_W), .VA_W(VA_W), .WORD_W(WORD_W)) u_step (
    .seg_i(req_seg), .va_i(req_va), .en_i(req_step), .back_i(req_back),
    .seg_o(seg_n), .va_o(va_n)
  );

  pmap_classify #(.ENTRY_W(ENTRY_W)) u_cls (
    .entry_i(ram_q), .is_wr_i(wr_q), .wdata_o(cls_wdata),
    .need_wr_o(cls_need_wr), .fault_o(cls_fault), .retry_o(cls_retry)
  );

  assign map_wr_stb  = (st == ST_CLASS) && cls_need_wr;
  assign map_wr_data = cls_wdata;

  pmap_ram #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_ram (
    .clk(clk), .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data),
    .upd_we(map_wr_stb), .upd_idx(idx), .upd_data(cls_wdata),
    .rd_idx(idx), .rd_data(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      seg_q     <= '0;
      va_q      <= '0;
      wr_q      <= 1'b0;
      done      <= 1'b0;
      fault_src <= 1'b0;
      fault_dst <= 1'b0;
      real_addr <= '0;
    end else begin
      done      <= 1'b0;
      fault_src <= 1'b0;
      fault_dst <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          seg_q <= seg_n;
          va_q  <= va_n;
          wr_q  <= req_write;
          st    <= ST_LOOK;
        end
        ST_LOOK: st <= ST_CLASS;
        ST_CLASS: begin
          if (cls_fault) begin
            fault_src <= !wr_q;
            fault_dst <= wr_q;
            st        <= ST_IDLE;
          end else if (cls_retry) begin
            st <= ST_LOOK;
          end else begin
            done      <= 1'b1;
            real_addr <= {ram_q[ENTRY_W-1:FLAG_W], va_q[WORD_W-1:0]};
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault_src, fault_dst}));
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault_src || fault_dst) |=> !(done || fault_src || fault_dst));
  p_wr_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_stb |-> ((map_wr_data & ~ram_q) != '0));
  p_ref_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_stb |-> (map_wr_data[FLAG_W-1] && (map_wr_data[ENTRY_W-1:FLAG_W] == ram_q[ENTRY_W-1:FLAG_W])));
  p_nowr_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_src |-> !$past(map_wr_stb));
  p_nowr_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_dst |-> !$past(map_wr_stb));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !map_wr_stb);
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_step_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_step && !req_back) |=> (va_q == $past(req_va) + PAGE_STEP));
  p_step_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_step && req_back) |=> (va_q == $past(req_va) - PAGE_STEP));
  p_addr_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (real_addr[WORD_W-1:0] == va_q[WORD_W-1:0]));
endmodule

// File: tb/page_map_updater_tb_top.sv
module page_map_updater_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [11:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_step = 1'b0;
  logic        req_back = 1'b0;
  logic        fill_we = 1'b0;
  logic [7:0]  fill_idx = '0;
  logic [15:0] fill_data = '0;
  logic        map_wr_stb;
  logic [15:0] map_wr_data;
  logic [15:0] real_addr;
  logic        done, fault_src, fault_dst;

  int n_chk = 0;
  int n_fail = 0;

  logic        r_done, r_fs, r_fd, r_busy_ready, r_timeout;
  int          r_nwr;
  logic [15:0] r_wdata, r_addr;

  always #5 clk = ~clk;

  page_map_updater dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_va(req_va), .req_write(req_write),
    .req_step(req_step), .req_back(req_back), .fill_we(fill_we),
    .fill_idx(fill_idx), .fill_data(fill_data), .map_wr_stb(map_wr_stb),
    .map_wr_data(map_wr_data), .real_addr(real_addr), .done(done),
    .fault_src(fault_src), .fault_dst(fault_dst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] idx, input logic [15:0] data);
    @(negedge clk);
    fill_we = 1'b1; fill_idx = idx; fill_data = data;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] seg, input logic [11:0] va,
                        input logic wr, input logic step, input logic back);
    r_done = 0; r_fs = 0; r_fd = 0; r_nwr = 0; r_wdata = '0; r_addr = '0;
    r_timeout = 1'b1;
    @(negedge clk);
    req_seg = seg; req_va = va; req_write = wr; req_step = step; req_back = back;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_busy_ready = req_ready;
    for (int i = 0; i < 40; i++) begin
      if (map_wr_stb) begin r_nwr++; r_wdata = map_wr_data; end
      if (done || fault_src || fault_dst) begin
        r_done = done; r_fs = fault_src; r_fd = fault_dst; r_addr = real_addr;
        r_timeout = 1'b0;
        @(negedge clk);
        chk("R11 pulse length", {29'd0, done, fault_src, fault_dst}, 32'd0);
        break;
      end
      @(negedge clk);
    end
    chk("R11 op finished", {31'd0, r_timeout}, 32'd0);
    chk("R11 single result", {31'd0, 1'b0}, 32'(({r_done, r_fs, r_fd} != 3'b000) &&
        !$onehot({r_done, r_fs, r_fd})));
  endtask

  task automatic t_reset;
    chk("R12 ready", {31'd0, req_ready}, 32'd1);
    chk("R12 outputs", {28'd0, done, fault_src, fault_dst, map_wr_stb}, 32'd0);
  endtask

  task automatic t_read_ok;
    fill(8'h13, 16'h5A00);
    run_op(4'h1, 12'h345, 1'b0, 1'b0, 1'b0);
    chk("R1 ready low while busy", {31'd0, r_busy_ready}, 32'd0);
    chk("R2 clean read done", {31'd0, r_done}, 32'd1);
    chk("R2 one write", r_nwr, 1);
    chk("R2 write data", r_wdata, 16'h5A80);
    chk("R7 real addr", r_addr, 16'h5A45);
    run_op(4'h1, 12'h345, 1'b0, 1'b0, 1'b0);
    chk("R11 no rewrite when unchanged", r_nwr, 0);
    chk("R2 repeat done", {31'd0, r_done}, 32'd1);
    fill(8'h14, 16'h2104);
    run_op(4'h1, 12'h4C3, 1'b0, 1'b0, 1'b0);
    chk("R2 protected read done", {31'd0, r_done}, 32'd1);
    chk("R2 protected read wdata", r_wdata, 16'h2184);
    chk("R7 protected read addr", r_addr, 16'h21C3);
  endtask

  task automatic t_read_vacant;
    fill(8'h15, 16'h3308);
    run_op(4'h1, 12'h500, 1'b0, 1'b0, 1'b0);
    chk("R3 fault_src", {29'd0, r_done, r_fs, r_fd}, 32'b010);
    chk("R3 no write", r_nwr, 0);
  endtask

  task automatic t_write_clean;
    fill(8'h21, 16'h4400);
    run_op(4'h2, 12'h177, 1'b1, 1'b0, 1'b0);
    chk("R4 done after retry", {29'd0, r_done, r_fs, r_fd}, 32'b100);
    chk("R4 one write", r_nwr, 1);
    chk("R4 write data", r_wdata, 16'h44C0);
    chk("R7 write addr", r_addr, 16'h4477);
    run_op(4'h2, 12'h177, 1'b1, 1'b0, 1'b0);
    chk("R5 now dirty, no write", r_nwr, 0);
    chk("R5 now dirty, done", {31'd0, r_done}, 32'd1);
  endtask

  task automatic t_write_dirty;
    fill(8'h22, 16'h6640);
    run_op(4'h2, 12'h288, 1'b1, 1'b0, 1'b0);
    chk("R5 dirty done", {29'd0, r_done, r_fs, r_fd}, 32'b100);
    chk("R5 ref added", r_wdata, 16'h66C0);
    chk("R5 one write", r_nwr, 1);
    chk("R7 dirty addr", r_addr, 16'h6688);
  endtask

  task automatic t_write_fault;
    fill(8'h23, 16'h7704);
    run_op(4'h2, 12'h300, 1'b1, 1'b0, 1'b0);
    chk("R6 protected write fault", {29'd0, r_done, r_fs, r_fd}, 32'b001);
    chk("R6 protected no write", r_nwr, 0);
    fill(8'h24, 16'h7808);
    run_op(4'h2, 12'h400, 1'b1, 1'b0, 1'b0);
    chk("R6 vacant write fault", {29'd0, r_done, r_fs, r_fd}, 32'b001);
    chk("R6 vacant no write", r_nwr, 0);
  endtask

  task automatic t_priority;
    fill(8'h36, 16'h990C);
    run_op(4'h3, 12'h600, 1'b0, 1'b0, 1'b0);
    chk("R8 vacant beats protect", {29'd0, r_done, r_fs, r_fd}, 32'b010);
    fill(8'h37, 16'h9A44);
    run_op(4'h3, 12'h700, 1'b1, 1'b0, 1'b0);
    chk("R8 protect beats dirty", {29'd0, r_done, r_fs, r_fd}, 32'b001);
    chk("R8 no write", r_nwr, 0);
  endtask

  task automatic t_step_fwd;
    fill(8'h2F, 16'h0008);
    fill(8'h30, 16'hAB80);
    run_op(4'h2, 12'hF10, 1'b0, 1'b1, 1'b0);
    chk("R9 carry into segment", {29'd0, r_done, r_fs, r_fd}, 32'b100);
    chk("R9 carry addr", r_addr, 16'hAB10);
    fill(8'h01, 16'h0008);
    fill(8'h02, 16'hB180);
    run_op(4'h0, 12'h120, 1'b0, 1'b1, 1'b0);
    chk("R9 no carry addr", r_addr, 16'hB120);
  endtask

  task automatic t_step_back;
    fill(8'h10, 16'h0008);
    fill(8'h0F, 16'hC280);
    run_op(4'h1, 12'h005, 1'b0, 1'b1, 1'b1);
    chk("R10 borrow from segment", {29'd0, r_done, r_fs, r_fd}, 32'b100);
    chk("R10 borrow addr", r_addr, 16'hC205);
    fill(8'h35, 16'h0008);
    fill(8'h34, 16'hC380);
    run_op(4'h3, 12'h510, 1'b0, 1'b1, 1'b1);
    chk("R10 no borrow addr", r_addr, 16'hC310);
    run_op(4'h1, 12'h345, 1'b0, 1'b0, 1'b1);
    chk("R10 direction ignored without step", r_addr, 16'h5A45);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_read_vacant();
    t_write_clean();
    t_write_dirty();
    t_write_fault();
    t_priority();
    t_step_fwd();
    t_step_back();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule